// File: doc/BRIEF.md
# Fan Tachometer Capture Timer

This block times the period of a fan tachometer signal on two independent channels, A and B. Each channel owns a 16-bit counter that software preloads, normally to full scale 0xFFFF. Once the channel is started the counter counts down by one on every tick of a shared prescaler, so the ticks elapsed equal the preload minus the current count. The first falling edge of the channel's tach input after the start copies the counter into the channel's capture register and stops the counter. If the count instead reaches a programmed compare value first, a timeout is flagged. If the count would step below zero, an underflow is flagged. Software turns the captured tick count into fan speed: the tach gives two pulses per revolution, so captured ticks = f_clk·60 / ((DIV+1)·rpm·2). A reading is only meaningful while that figure stays inside the compare window.

Each channel is run by a small state machine with three states. IDLE is the stopped state; the counter holds its value and takes software loads. COUNT is the measuring state; the counter decrements on prescaler ticks and the channel watches for a tach edge, the compare match and underflow. DONE is the finished state; the counter is frozen. The transitions are as follows. The start transition goes from IDLE to COUNT when the channel's run bit is 1. The finish transition goes from COUNT to DONE on capture, timeout or underflow. The abort transition goes from COUNT to IDLE when the run bit is cleared. The rearm transition goes from DONE to IDLE when the run bit is cleared.

Six pending flags collect the events. Software clears them by writing ones, and a mask routes them onto one interrupt line.

Top module: `tach_capture_timer`

## Requirements
- R1: After reset both counters read 0xFFFF. Every other register reads 0, and `irq` is low.
- R2: The register map uses halfword byte offsets: counter A 0x00, counter B 0x02, capture A 0x04, capture B 0x06, compare A 0x08, compare B 0x0A, divider 0x0C (8 bits), run 0x0E (bit 0 A, bit 1 B), pending 0x10 (read only), acknowledge 0x12 (write only, reads 0), mask 0x14 (6 bits), compare mode 0x16 (bit 0 A, bit 1 B). A write stores only the bytes whose `bus_be` bit is set. The 8-bit registers take bits 7:0 when `bus_be[0]` is set. Every register except pending and acknowledge reads back what was written.
- R3: A channel is started by setting its run bit. The channel enters COUNT one clock after the write. While it is in COUNT, its counter decrements once every DIV+1 clocks. After the start write at edge W, the counter holds P − floor(m/(DIV+1)) after edge W+1+m, where P is the preload. A channel that is not in COUNT keeps its counter unchanged.
- R4: In COUNT, a falling tach edge copies the counter into the capture register and stops the counter, so the two then read equal. The edge is synchronised through two flops, so an input that goes low before edge T is captured at edge T+2. The capture sets pending bit 0 for A or bit 1 for B.
- R5: With the channel's compare-mode bit set, a counter equal to the compare value in COUNT sets pending bit 2 (A) or 3 (B) and stops the counter. The capture register and the capture flag stay untouched.
- R6: When a tach edge and a compare match fall in the same cycle, the capture wins and no timeout is flagged.
- R7: With the compare-mode bit clear, no timeout is ever flagged.
- R8: A prescaler tick that arrives while the counter is 0 in COUNT sets pending bit 4 (A) or 5 (B) and stops the channel with the counter at 0.
- R9: Only the first falling edge after the start counts. Edges seen while IDLE or DONE change neither the capture register nor any flag.
- R10: Writing ones to the acknowledge register with `bus_be[0]` set clears the matching pending bits. Zero bits, and writes with `bus_be[0]` clear, leave the flags as they are.
- R11: `irq` is high exactly when some pending bit and its mask bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Byte address of the halfword register |
| bus_wdata | input | 16 | Write data |
| bus_be | input | 2 | Byte enables for the write |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| tach_in | input | 2 | Tach inputs, bit 0 channel A, bit 1 channel B |
| irq | output | 1 | Masked OR of the pending flags |

## Verification
The assertions assume three things. The tach inputs idle high, so only a falling transition counts as an edge. A channel's counter is never loaded by software in the same cycle as one of its events. A restart always passes through the abort or rearm transition, because the run bit is cleared before it is set again. The stimulus meets these by writing the run register to 0 before any preload and by holding each tach high outside a measurement. It also drives a falling edge only after a known number of clocks from the start write. That fixed spacing lets the expected capture, timeout or underflow be worked out exactly, including the tie between an edge and a compare match.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

    localparam int unsigned NUM_CH = 2;

    // channel state machine
    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,
        CH_COUNT = 2'd1,
        CH_DONE  = 2'd2
    } ch_state_e;

    // byte offsets of the halfword registers
    localparam int unsigned OFS_CNT_BASE = 'h00;  // + 2*channel
    localparam int unsigned OFS_CAP_BASE = 'h04;  // + 2*channel
    localparam int unsigned OFS_CMP_BASE = 'h08;  // + 2*channel
    localparam int unsigned OFS_DIV      = 'h0C;
    localparam int unsigned OFS_RUN      = 'h0E;
    localparam int unsigned OFS_PEND     = 'h10;
    localparam int unsigned OFS_ACK      = 'h12;
    localparam int unsigned OFS_MASK     = 'h14;
    localparam int unsigned OFS_MODE     = 'h16;

endpackage

// File: rtl/tcap_prescaler.sv
module tcap_prescaler #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] pre_q;

    assign tick = active && (pre_q == div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!active || tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

endmodule

// File: rtl/tcap_tach_sync.sv
module tcap_tach_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tach,
    output logic fall
);

    logic [STAGES-1:0] sh_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '1;
                else        sh_q <= tach;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= '1;
                else        sh_q <= {sh_q[STAGES-2:0], tach};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sh_q[STAGES-1];
    end

    assign fall = prev_q && !sh_q[STAGES-1];

endmodule

// File: rtl/tcap_channel.sv
module tcap_channel
    import tcap_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             eq_mode,
    input  logic             tick,
    input  logic             fall,
    input  logic [CNT_W-1:0] cmp_val,
    input  logic             cnt_ld,
    input  logic [CNT_W-1:0] cnt_ld_val,
    input  logic             cap_ld,
    input  logic [CNT_W-1:0] cap_ld_val,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cap_o,
    output logic             counting_o,
    output logic             ev_cap_o,
    output logic             ev_to_o,
    output logic             ev_uf_o
);

    ch_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cap_q;
    logic             dec;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (run) state_d = CH_COUNT;               // start
            end
            CH_COUNT: begin
                if (!run)                                 state_d = CH_IDLE;  // abort
                else if (ev_cap_o || ev_to_o || ev_uf_o)  state_d = CH_DONE;  // finish
            end
            CH_DONE: begin
                if (!run) state_d = CH_IDLE;               // rearm
            end
            default: state_d = CH_IDLE;
        endcase
    end

    // outputs: edge beats compare, compare beats underflow
    always_comb begin
        counting_o = (state_q == CH_COUNT);
        ev_cap_o   = 1'b0;
        ev_to_o    = 1'b0;
        ev_uf_o    = 1'b0;
        dec        = 1'b0;
        if (counting_o && run) begin
            if (fall) begin
                ev_cap_o = 1'b1;
            end else if (eq_mode && (cnt_q == cmp_val)) begin
                ev_to_o = 1'b1;
            end else if (tick) begin
                if (cnt_q == '0) ev_uf_o = 1'b1;
                else             dec     = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '1;
        else if (cnt_ld) cnt_q <= cnt_ld_val;
        else if (dec)    cnt_q <= cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cap_q <= '0;
        else if (ev_cap_o) cap_q <= cnt_q;
        else if (cap_ld)   cap_q <= cap_ld_val;
    end

    assign cnt_o = cnt_q;
    assign cap_o = cap_q;

endmodule

// File: rtl/tach_capture_timer.sv
module tach_capture_timer
    import tcap_pkg::*;
#(
    parameter int unsigned CNT_W       = 16,
    parameter int unsigned DIV_W       = 8,
    parameter int unsigned ADDR_W      = 5,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [CNT_W-1:0]    bus_wdata,
    input  logic [CNT_W/8-1:0]  bus_be,
    input  logic                bus_wr,
    output logic [CNT_W-1:0]    bus_rdata,
    input  logic [NUM_CH-1:0]   tach_in,
    output logic                irq
);

    localparam int unsigned BE_W   = CNT_W / 8;
    localparam int unsigned PEND_W = 3 * NUM_CH;

    function automatic logic [CNT_W-1:0] merge_be(input logic [CNT_W-1:0] cur,
                                                  input logic [CNT_W-1:0] nw,
                                                  input logic [BE_W-1:0]  be);
        logic [CNT_W-1:0] r;
        r = cur;
        for (int b = 0; b < BE_W; b++) begin
            if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
        end
        return r;
    endfunction

    function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned ofs);
        return bus_wr && (a == ADDR_W'(ofs));
    endfunction

    logic [DIV_W-1:0]             div_q;
    logic [NUM_CH-1:0]            run_q, mode_q;
    logic [PEND_W-1:0]            pend_q, mask_q, ack_clr, ev_all;
    logic [CNT_W-1:0]             cmp_q [NUM_CH];
    logic [NUM_CH-1:0][CNT_W-1:0] cnt_w, cap_w;
    logic [NUM_CH-1:0]            counting, ev_cap, ev_to, ev_uf, fall, cnt_ld, cap_ld;
    logic                         tick;

    tcap_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (|counting),
        .div    (div_q),
        .tick   (tick)
    );

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            localparam int unsigned A_CNT = OFS_CNT_BASE + 2 * g;
            localparam int unsigned A_CAP = OFS_CAP_BASE + 2 * g;
            localparam int unsigned A_CMP = OFS_CMP_BASE + 2 * g;

            assign cnt_ld[g] = hit(bus_addr, A_CNT);
            assign cap_ld[g] = hit(bus_addr, A_CAP);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                 cmp_q[g] <= '0;
                else if (hit(bus_addr, A_CMP)) cmp_q[g] <= merge_be(cmp_q[g], bus_wdata, bus_be);
            end

            tcap_tach_sync #(.STAGES(SYNC_STAGES)) u_sync (
                .clk   (clk),
                .rst_n (rst_n),
                .tach  (tach_in[g]),
                .fall  (fall[g])
            );

            tcap_channel #(.CNT_W(CNT_W)) u_ch (
                .clk        (clk),
                .rst_n      (rst_n),
                .run        (run_q[g]),
                .eq_mode    (mode_q[g]),
                .tick       (tick),
                .fall       (fall[g]),
                .cmp_val    (cmp_q[g]),
                .cnt_ld     (cnt_ld[g]),
                .cnt_ld_val (merge_be(cnt_w[g], bus_wdata, bus_be)),
                .cap_ld     (cap_ld[g]),
                .cap_ld_val (merge_be(cap_w[g], bus_wdata, bus_be)),
                .cnt_o      (cnt_w[g]),
                .cap_o      (cap_w[g]),
                .counting_o (counting[g]),
                .ev_cap_o   (ev_cap[g]),
                .ev_to_o    (ev_to[g]),
                .ev_uf_o    (ev_uf[g])
            );
        end
    endgenerate

    // byte-wide control registers take the low byte only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            run_q  <= '0;
            mask_q <= '0;
            mode_q <= '0;
        end else if (bus_be[0]) begin
            if (hit(bus_addr, OFS_DIV))  div_q  <= bus_wdata[DIV_W-1:0];
            if (hit(bus_addr, OFS_RUN))  run_q  <= bus_wdata[NUM_CH-1:0];
            if (hit(bus_addr, OFS_MASK)) mask_q <= bus_wdata[PEND_W-1:0];
            if (hit(bus_addr, OFS_MODE)) mode_q <= bus_wdata[NUM_CH-1:0];
        end
    end

    assign ack_clr = (hit(bus_addr, OFS_ACK) && bus_be[0]) ? bus_wdata[PEND_W-1:0] : '0;
    assign ev_all  = {ev_uf, ev_to, ev_cap};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~ack_clr) | ev_all;
    end

    assign irq = |(pend_q & mask_q);

    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (bus_addr == ADDR_W'(OFS_CNT_BASE + 2 * c)) bus_rdata = cnt_w[c];
            if (bus_addr == ADDR_W'(OFS_CAP_BASE + 2 * c)) bus_rdata = cap_w[c];
            if (bus_addr == ADDR_W'(OFS_CMP_BASE + 2 * c)) bus_rdata = cmp_q[c];
        end
        if (bus_addr == ADDR_W'(OFS_DIV))  bus_rdata = CNT_W'(div_q);
        if (bus_addr == ADDR_W'(OFS_RUN))  bus_rdata = CNT_W'(run_q);
        if (bus_addr == ADDR_W'(OFS_PEND)) bus_rdata = CNT_W'(pend_q);
        if (bus_addr == ADDR_W'(OFS_MASK)) bus_rdata = CNT_W'(mask_q);
        if (bus_addr == ADDR_W'(OFS_MODE)) bus_rdata = CNT_W'(mode_q);
    end

endmodule

// File: rtl/tcap_checker.sv
module tcap_checker
    import tcap_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_CH-1:0][CNT_W-1:0] cnt,
    input logic [NUM_CH-1:0][CNT_W-1:0] cap,
    input logic [NUM_CH-1:0]            counting,
    input logic [NUM_CH-1:0]            ev_cap,
    input logic [NUM_CH-1:0]            ev_to,
    input logic [NUM_CH-1:0]            cnt_ld,
    input logic [NUM_CH-1:0]            cap_ld
);

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
            // R4
            cap_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (ev_cap[g] && !cnt_ld[g] && !cap_ld[g]) |=> (cap[g] == cnt[g]));

            // R6
            cap_to_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(ev_cap[g] && ev_to[g]));

            // R3
            step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (counting[g] && !cnt_ld[g]) |=>
                    ((cnt[g] == $past(cnt[g])) || (cnt[g] == ($past(cnt[g]) - CNT_W'(1)))));

            // R3
            hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!counting[g] && !cnt_ld[g]) |=> $stable(cnt[g]));
        end
    endgenerate

endmodule

bind tach_capture_timer tcap_checker #(.CNT_W(CNT_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt      (cnt_w),
    .cap      (cap_w),
    .counting (counting),
    .ev_cap   (ev_cap),
    .ev_to    (ev_to),
    .cnt_ld   (cnt_ld),
    .cap_ld   (cap_ld)
);

// File: tb/tach_capture_timer_tb_top.sv
module tach_capture_timer_tb_top;

    localparam int unsigned CLK_PERIOD = 10;

    localparam logic [4:0] A_CNTA = 5'h00, A_CNTB = 5'h02, A_CAPA = 5'h04, A_CAPB = 5'h06,
                           A_CMPA = 5'h08, A_CMPB = 5'h0A, A_DIV  = 5'h0C, A_RUN  = 5'h0E,
                           A_PEND = 5'h10, A_ACK  = 5'h12, A_MASK = 5'h14, A_MODE = 5'h16;

    typedef struct packed {
        logic [15:0] pre;
        logic [15:0] cmp;
        logic [7:0]  div;
        logic        mode;
        logic [15:0] gap;
        logic [5:0]  pend;
        logic [15:0] cap;
        logic [15:0] cnt;
    } vec_t;

    // expected values from R3..R7: capture = P - floor(gap/(DIV+1)) when
    // gap <= (P-C)*(DIV+1) or mode off, else timeout with count = C
    localparam vec_t VECS [8] = '{
        '{16'hFFFF, 16'hAFFF, 8'd0,   1'b1, 16'd10,   6'h01, 16'hFFF5, 16'hFFF5},
        '{16'hFFFF, 16'hFFF0, 8'd0,   1'b1, 16'd40,   6'h04, 16'hFFFF, 16'hFFF0},
        '{16'h0100, 16'h00F0, 8'd3,   1'b1, 16'd37,   6'h01, 16'h00F7, 16'h00F7},
        '{16'h0100, 16'h00F0, 8'd3,   1'b1, 16'd64,   6'h01, 16'h00F0, 16'h00F0},
        '{16'h0100, 16'h00F0, 8'd3,   1'b1, 16'd65,   6'h04, 16'hFFFF, 16'h00F0},
        '{16'h0100, 16'h00F0, 8'd3,   1'b0, 16'd100,  6'h01, 16'h00E7, 16'h00E7},
        '{16'h0020, 16'h0020, 8'd0,   1'b1, 16'd1,    6'h04, 16'hFFFF, 16'h0020},
        '{16'hFFFF, 16'hAFFF, 8'd255, 1'b1, 16'd1000, 6'h01, 16'hFFFC, 16'hFFFC}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [1:0]  bus_be = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_rdata;
    logic [1:0]  tach_in = 2'b11;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tach_capture_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_be    (bus_be),
        .bus_wr    (bus_wr),
        .bus_rdata (bus_rdata),
        .tach_in   (tach_in),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // start: run write lands at edge W, tach low is sampled at edge W+gap
    task automatic start(input logic [1:0] runv, input int ch, input int gap);
        wr(A_RUN, {14'd0, runv}, 2'b01);
        repeat (gap - 1) @(negedge clk);
        tach_in[ch] = 1'b0;
    endtask

    task automatic prep(input logic [4:0] cnta, input logic [15:0] p, input logic [15:0] c,
                        input logic [7:0] d, input logic [1:0] mode);
        wr(A_RUN, 16'h0, 2'b01);
        tach_in = 2'b11;
        wr(A_DIV, {8'h0, d}, 2'b01);
        wr(A_MODE, {14'd0, mode}, 2'b01);
        wr(A_CMPA, c, 2'b11);
        wr(cnta, p, 2'b11);
        wr(cnta + 5'h4, 16'hFFFF, 2'b11);
        wr(A_ACK, 16'h003F, 2'b01);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: got hung expected done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_CNTA, v); chk("R1 cnt A", v, 16'hFFFF);
        rd(A_CNTB, v); chk("R1 cnt B", v, 16'hFFFF);
        rd(A_CAPA, v); chk("R1 cap A", v, 16'h0000);
        rd(A_PEND, v); chk("R1 pend", v, 16'h0000);
        rd(A_MASK, v); chk("R1 mask", v, 16'h0000);
        chk("R1 irq", {15'd0, irq}, 16'h0000);

        // R2 register readback and byte enables
        wr(A_CMPB, 16'hBEEF, 2'b11);
        rd(A_CMPB, v); chk("R2 cmp B", v, 16'hBEEF);
        wr(A_CMPB, 16'h1200, 2'b10);
        rd(A_CMPB, v); chk("R2 cmp B high byte", v, 16'h12EF);
        wr(A_DIV, 16'h3456, 2'b10);
        rd(A_DIV, v); chk("R2 div ignores be1", v, 16'h0000);
        wr(A_MASK, 16'h003F, 2'b01);
        rd(A_MASK, v); chk("R2 mask", v, 16'h003F);
        rd(A_ACK, v); chk("R2 ack reads 0", v, 16'h0000);

        // vector table, channel A
        for (int i = 0; i < 8; i++) begin
            prep(A_CNTA, VECS[i].pre, VECS[i].cmp, VECS[i].div, {1'b0, VECS[i].mode});
            start(2'b01, 0, int'(VECS[i].gap));
            repeat (8) @(negedge clk);
            tach_in[0] = 1'b1;
            rd(A_PEND, v); chk($sformatf("R4/R5/R6/R7 pend vec%0d", i), v, {10'd0, VECS[i].pend});
            rd(A_CAPA, v); chk($sformatf("R4/R5 cap vec%0d", i), v, VECS[i].cap);
            rd(A_CNTA, v); chk($sformatf("R3 cnt vec%0d", i), v, VECS[i].cnt);
            chk($sformatf("R11 irq vec%0d", i), {15'd0, irq}, 16'h0001);
        end

        // R9: second edge after capture is ignored (last vector captured 0xFFFC)
        wr(A_ACK, 16'h003F, 2'b01);
        repeat (3) @(negedge clk);
        tach_in[0] = 1'b0;
        repeat (8) @(negedge clk);
        tach_in[0] = 1'b1;
        rd(A_PEND, v); chk("R9 pend after late edge", v, 16'h0000);
        rd(A_CAPA, v); chk("R9 cap after late edge", v, 16'hFFFC);

        // R9: edge while idle ignored
        prep(A_CNTA, 16'h0800, 16'h0000, 8'd0, 2'b00);
        tach_in[0] = 1'b0;
        repeat (6) @(negedge clk);
        wr(A_RUN, 16'h1, 2'b01);
        repeat (20) @(negedge clk);
        rd(A_PEND, v); chk("R9 pend idle edge", v, 16'h0000);
        rd(A_CAPA, v); chk("R9 cap idle edge", v, 16'hFFFF);

        // R3: stopped channel holds its count; idle channel B untouched
        wr(A_RUN, 16'h0, 2'b01);
        wr(A_CNTA, 16'h1000, 2'b11);
        repeat (20) @(negedge clk);
        rd(A_CNTA, v); chk("R3 hold while stopped", v, 16'h1000);
        rd(A_CNTB, v); chk("R3 channel B untouched", v, 16'hFFFF);

        // R8 underflow: P=5, DIV=1, no edge, mode off
        tach_in = 2'b11;
        prep(A_CNTA, 16'h0005, 16'h0000, 8'd1, 2'b00);
        wr(A_RUN, 16'h1, 2'b01);
        repeat (30) @(negedge clk);
        rd(A_PEND, v); chk("R8 underflow flag", v, 16'h0010);
        rd(A_CNTA, v); chk("R8 count at 0", v, 16'h0000);

        // R4 channel B capture, gap 20, DIV 0
        prep(A_CNTA, 16'hFFFF, 16'h0000, 8'd0, 2'b00);
        wr(A_CNTB, 16'hFFFF, 2'b11);
        wr(A_CAPB, 16'hFFFF, 2'b11);
        start(2'b10, 1, 20);
        repeat (8) @(negedge clk);
        tach_in[1] = 1'b1;
        rd(A_PEND, v); chk("R4 B pend", v, 16'h0002);
        rd(A_CAPB, v); chk("R4 B cap", v, 16'hFFEB);

        // R10 acknowledge rules
        wr(A_ACK, 16'h0002, 2'b10);
        rd(A_PEND, v); chk("R10 ack without be0", v, 16'h0002);
        wr(A_ACK, 16'h0001, 2'b01);
        rd(A_PEND, v); chk("R10 ack other bit", v, 16'h0002);

        // R11 mask
        wr(A_MASK, 16'h0001, 2'b01);
        chk("R11 irq masked", {15'd0, irq}, 16'h0000);
        wr(A_MASK, 16'h0002, 2'b01);
        chk("R11 irq unmasked", {15'd0, irq}, 16'h0001);

        wr(A_ACK, 16'h0002, 2'b01);
        rd(A_PEND, v); chk("R10 ack clears", v, 16'h0000);
        chk("R11 irq cleared", {15'd0, irq}, 16'h0000);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule